// File: doc/BRIEF.md
# Clock timer interrupt flag unit

The block turns a 32.768 kHz timekeeping clock into four periodic interrupt sources and merges them onto one level request line for an external interrupt controller. A free-running binary counter runs at the timekeeping rate. Four of its bits are square waves at 32 Hz, 8 Hz, 2 Hz and 1 Hz. A source fires when its wave goes from 1 to 0.

Each source has an enable bit in a mask register and a sticky flag bit in a flag register. A source whose enable is 0 never sets its flag. The request output is high while any flag is set. The interrupt handler reads the flag register to find out which rate fired, then writes ones to the flag register to clear the bits it has handled.

Top module: `ctick_irq`

## Requirements
- R1: A synchronous active-high reset clears the counter, all four enable bits and all four flag bits, and holds `irq` low.
- R2: The counter starts at 0 after reset and adds 1 on every clock. Tap bit b (defaults: 9, 11, 13 and 14 for 32, 8, 2 and 1 Hz) makes an event at clock edge k after reset release, counting from k = 0, when k > 0 and k is a multiple of 2^(b+1). That is the 1-to-0 transition of the tap.
- R3: While the enable bit of a source is 0, its events do not set its flag.
- R4: The flag register is at offset 3 and the mask register is at offset 2. Both use the same bit order: bit 3 = 32 Hz, bit 2 = 8 Hz, bit 1 = 2 Hz, bit 0 = 1 Hz.
- R5: A set flag stays set until software clears it.
- R6: A write of 1 to a flag bit at offset 3 clears that bit, and a write of 0 leaves it unchanged. If an enabled event and a clear hit the same bit on the same edge, the bit ends up set.
- R7: `irq` is 1 exactly when at least one flag bit is 1.
- R8: Read data bits 7..4 are always 0. A read of any offset other than 2 or 3 returns 0. Writes to those offsets, and to bits 7..4, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe for the current offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Shared level interrupt request |

## Verification
The bench builds the unit with a 6-bit counter and taps at bits 1, 2, 4 and 5. The four sources then fire every 4, 8, 32 and 64 clocks instead of after thousands of clocks. With these values the bench can reach, in a short run, the first event of every rate, a counter wrap that is itself a falling edge of the top tap, and a clear placed exactly on the edge where a 32 Hz event occurs. The bit order and the edge arithmetic do not depend on the counter width, so the same checks apply to the default build.

// File: rtl/ctick_irq.sv
module ctick_irq #(
  parameter int CNT_W  = 15,
  parameter int TAP_HI = 9,
  parameter int TAP_MH = 11,
  parameter int TAP_ML = 13,
  parameter int TAP_LO = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] FLAG_OFS = ADDR_W'(3);

  logic [CNT_W-1:0] cnt;
  logic [3:0] tap_now, tap_q, fall, mask, flag, clr;
  logic wr_mask, wr_flag;

  assign tap_now = {cnt[TAP_HI], cnt[TAP_MH], cnt[TAP_ML], cnt[TAP_LO]};
  assign fall    = tap_q & ~tap_now;
  assign wr_mask = wr_en && addr == MASK_OFS;
  assign wr_flag = wr_en && addr == FLAG_OFS;
  assign clr     = wr_flag ? wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      tap_q <= '0;
      mask  <= '0;
      flag  <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
      tap_q <= tap_now;
      flag  <= (flag & ~clr) | (fall & mask);
      if (wr_mask) mask <= wdata[3:0];
    end
  end

  assign rdata = (addr == MASK_OFS) ? {4'b0, mask} :
                 (addr == FLAG_OFS) ? {4'b0, flag} : 8'h00;
  assign irq   = |flag;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (mask == 4'b0 && flag == 4'b0 && !irq)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1); // R2

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(rst) || $past(wr_flag))); // R7

  for (genvar i = 0; i < 4; i++) begin : g_chk
    AST_RISE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[i]) |-> $past(fall[i] && mask[i])); // R3

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !(wr_flag && wdata[i])) |=> flag[i]); // R5
  end

endmodule

// File: tb/sim_ctick_irq.sv
module sim_ctick_irq;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [3:0] addr = 4'd3;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  int mt = 0;
  logic [3:0] mf = 0, mm = 0;
  int per [4] = '{64, 32, 8, 4};

  always #2 clk = ~clk;

  ctick_irq #(.CNT_W(6), .TAP_HI(1), .TAP_MH(2), .TAP_ML(4), .TAP_LO(5), .ADDR_W(4)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) begin
    logic [3:0] ev, cl;
    if (rst) begin
      mt = 0; mf = 0; mm = 0;
    end else begin
      cl = (wr_en && addr == 4'd3) ? wdata[3:0] : 4'b0;
      for (int i = 0; i < 4; i++) ev[i] = (mt > 0 && mt % per[i] == 0);
      mf = (mf & ~cl) | (ev & mm);
      if (wr_en && addr == 4'd2) mm = wdata[3:0];
      mt++;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic [7:0] e;
    @(posedge clk); #1;
    e = (addr == 4'd3) ? {4'b0, mf} : (addr == 4'd2) ? {4'b0, mm} : 8'h00;
    chk("R2 R3 R5 model rdata", rdata, e);
    chk("R7 model irq", {7'b0, irq}, {7'b0, mf != 0});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    cyc();
    wr_en = 0; addr = 4'd3; wdata = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    run(3);
    rst = 0;
    cyc();
    chk("R1 flags after reset", rdata, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    addr = 4'd2; #1;
    chk("R1 mask after reset", rdata, 8'h00);
    addr = 4'd3;
    run(150);
    chk("R3 masked sources stay clear", rdata, 8'h00);
    wr(4'd2, 8'h01);
    run(200);
    chk("R4 only 1Hz flag in bit 0", rdata, 8'h01);
    run(100);
    chk("R5 flag sticky", rdata, 8'h01);
    wr(4'd3, 8'h0E);
    chk("R6 zero write keeps flag", rdata, 8'h01);
    wr(4'd3, 8'h01);
    chk("R6 one write clears flag", rdata, 8'h00);
    chk("R7 irq low with no flags", {7'b0, irq}, 8'h00);
    wr(4'd2, 8'h0F);
    run(70);
    chk("R4 all four flags", rdata, 8'h0F);
    chk("R7 irq high", {7'b0, irq}, 8'h01);
    while (mt % 4 != 0) cyc();
    wr(4'd3, 8'h08);
    chk("R6 set wins on collision", {7'b0, rdata[3]}, 8'h01);
    while (mt % 4 != 2) cyc();
    wr(4'd3, 8'h08);
    chk("R6 clear off event", {7'b0, rdata[3]}, 8'h00);
    wr(4'd0, 8'hFF);
    addr = 4'd0; #1;
    chk("R8 unused offset reads zero", rdata, 8'h00);
    addr = 4'd2; #1;
    chk("R8 unused write ignored", rdata, 8'h0F);
    addr = 4'd3;
    wr(4'd2, 8'hF0);
    addr = 4'd2; #1;
    chk("R8 upper write bits ignored", rdata, 8'h00);
    addr = 4'd3;
    wr(4'd3, 8'hFF);
    run(130);
    chk("R3 disabled after clear stays clear", rdata, 8'h00);
    chk("R8 upper read bits zero", {4'b0, rdata[7:4]}, 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule